// File: doc/BRIEF.md
# Audio DAC Control Register Bank with I2C Target

This block is the control-plane front end of a stereo playback DAC. An external controller reaches it over a two-wire I2C bus. The block samples SCL and SDA with its own system clock and pulls SDA low through an open-drain enable. It keeps the DAC's 16-bit control words and presents them in parallel to the datapath: the power state, the audio port setup, the clocking setup, the DAC control bits, the left and right volume words and the zero-detect setup.

Each transfer begins with an 8-bit register index, and the data words are 16 bits wide. A write sends the index and then the data word, high byte first. A read first writes only the index. After a repeated start, the block returns the word high byte first. Index 0 holds a fixed identity word and index 1 holds a fixed revision number, and neither can be written. Any write to index 0 is instead taken as a soft reset that returns every writable word to its default.

Top module: `codec_ctl_regs`

## Requirements
- R1: The block acknowledges only its own 7-bit bus address `DEV_ADDR` (default 0x1A). A frame sent to any other address gets no acknowledge and changes nothing.
- R2: A write frame is device address with R/W=0, register index, data high byte, data low byte. Each of these bytes is acknowledged, and the register takes the new 16-bit value once the low byte is received.
- R3: A read frame is device address with R/W=0 and the register index, then a repeated start, then device address with R/W=1. The block then returns the word high byte first, MSB first.
- R4: A register index above 8 is not acknowledged, and no register changes.
- R5: Index 0 reads 0x8523 and index 1 reads 0x0001. Writes to index 1 are acknowledged and change neither its value nor any output.
- R6: Any data written to index 0 returns registers 2 to 8 to their defaults.
- R7: The defaults of registers 2..8 are 0x0000, 0x1812, 0x0000, 0x0001, 0x0190, 0x0190 and 0x0000. Outputs `port_cfg`, `clk_cfg`, `dac_ctl`, `vol_l`, `vol_r` and `zdet_cfg` show registers 3..8.
- R8: `pwr_state` is bits [1:0] of register 2, coded as 0 off, 1 initial power-up, 2 powered and muted, 3 fully on.
- R9: If the initiator acknowledges past the second read byte, the block keeps sending the same word, alternating high and low bytes.
- R10: `sda_oe` changes only while SCL is low.
- R11: During and after reset, `sda_oe` is low and every register holds its default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin (wired value) |
| sda_oe | output | 1 | High pulls SDA low |
| pwr_state | output | 2 | Power state field of register 2 |
| port_cfg | output | 16 | Register 3, audio port setup |
| clk_cfg | output | 16 | Register 4, clock ratio setup |
| dac_ctl | output | 16 | Register 5, DAC control bits |
| vol_l | output | 16 | Register 6, left volume word |
| vol_r | output | 16 | Register 7, right volume word |
| zdet_cfg | output | 16 | Register 8, zero-detect setup |

## Verification
The assertions take for granted that SCL stays high or low for at least three system clocks between changes, and that the initiator changes SDA only while SCL is low, except for start and stop. The bench initiator changes SCL and SDA only at quarter-bit points five system clocks apart. It moves SDA a quarter bit after the SCL falling edge and samples in the middle of the SCL high time, so the synchronized view never sees a false start or stop. Every check on the parallel outputs is made between frames, when no write can be in flight.

// File: rtl/codec_ctl_regs.sv
`timescale 1ns/1ps
module codec_ctl_regs #(
  parameter logic [6:0]  DEV_ADDR = 7'h1A,
  parameter int          NUM_REGS = 9,
  parameter logic [15:0] ID_WORD  = 16'h8523,
  parameter logic [2:0]  REV_WORD = 3'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [1:0]  pwr_state,
  output logic [15:0] port_cfg,
  output logic [15:0] clk_cfg,
  output logic [15:0] dac_ctl,
  output logic [15:0] vol_l,
  output logic [15:0] vol_r,
  output logic [15:0] zdet_cfg
);
  localparam logic [7:0] TOP_ADDR = 8'(NUM_REGS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_MACK, S_IGN} st_t;
  typedef enum logic [2:0] {P_DEV, P_REG, P_HI, P_LO, P_END} ph_t;

  function automatic logic [15:0] dflt(input int i);
    case (i)
      3:       return 16'h1812;
      5:       return 16'h0001;
      6, 7:    return 16'h0190;
      default: return 16'h0000;
    endcase
  endfunction

  logic [2:0]  scl_s, sda_s;
  st_t         st;
  ph_t         ph;
  logic [3:0]  cnt;
  logic [7:0]  sh, tx, ptr, hold;
  logic        rd, sel_lo, ack;
  logic [15:0] rd_word;
  logic [15:0] rf [2:NUM_REGS-1];

  wire scl_q = scl_s[1];
  wire scl_p = scl_s[2];
  wire sda_q = sda_s[1];
  wire sda_p = sda_s[2];
  wire rise  = scl_q & ~scl_p;
  wire fall  = ~scl_q & scl_p;
  wire start = scl_q & scl_p & sda_p & ~sda_q;
  wire stop  = scl_q & scl_p & ~sda_p & sda_q;

  wire byte_done = fall && st == S_RX && cnt == 4'd8;
  wire dev_hit   = sh[7:1] == DEV_ADDR;
  wire reg_ok    = sh <= TOP_ADDR;
  wire wr_en     = byte_done && ph == P_LO;

  always_comb begin
    case (ph)
      P_DEV:      ack = dev_hit;
      P_REG:      ack = reg_ok;
      P_HI, P_LO: ack = 1'b1;
      default:    ack = 1'b0;
    endcase
  end

  always_comb begin
    rd_word = 16'h0000;
    if (ptr == 8'd0) rd_word = ID_WORD;
    else if (ptr == 8'd1) rd_word = {13'd0, REV_WORD};
    for (int i = 2; i < NUM_REGS; i++)
      if (ptr == 8'(i)) rd_word = rf[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_DEV; cnt <= 4'd0; sh <= 8'd0; tx <= 8'd0;
      ptr <= 8'd0; hold <= 8'd0; rd <= 1'b0; sel_lo <= 1'b0; sda_oe <= 1'b0;
    end else if (start) begin
      st <= S_RX; ph <= P_DEV; cnt <= 4'd0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (rise) begin
            sh  <= {sh[6:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (ack) begin
              sda_oe <= 1'b1;
              st     <= S_RACK;
              case (ph)
                P_DEV: begin rd <= sh[0]; ph <= sh[0] ? P_END : P_REG; end
                P_REG: begin ptr <= sh; ph <= P_HI; end
                P_HI:  begin hold <= sh; ph <= P_LO; end
                default: ph <= P_END;
              endcase
            end else begin
              st <= S_IGN;
            end
          end
        S_RACK:
          if (fall) begin
            cnt <= 4'd0;
            if (rd) begin
              st <= S_TX; tx <= rd_word[15:8]; sda_oe <= ~rd_word[15]; sel_lo <= 1'b1;
            end else begin
              st <= S_RX; sda_oe <= 1'b0;
            end
          end
        S_TX:
          if (rise) cnt <= cnt + 4'd1;
          else if (fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0; st <= S_MACK;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
        S_MACK:
          if (rise && sda_q) st <= S_IGN;
          else if (fall) begin
            st <= S_TX; cnt <= 4'd0; sel_lo <= ~sel_lo;
            if (sel_lo) begin tx <= rd_word[7:0];  sda_oe <= ~rd_word[7];  end
            else        begin tx <= rd_word[15:8]; sda_oe <= ~rd_word[15]; end
          end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 2; i < NUM_REGS; i++) rf[i] <= dflt(i);
    end else if (wr_en) begin
      for (int i = 2; i < NUM_REGS; i++)
        if (ptr == 8'd0) rf[i] <= dflt(i);
        else if (ptr == 8'(i)) rf[i] <= {hold, sh};
    end
  end

  assign pwr_state = rf[2][1:0];
  assign port_cfg  = rf[3];
  assign clk_cfg   = rf[4];
  assign dac_ctl   = rf[5];
  assign vol_l     = rf[6];
  assign vol_r     = rf[7];
  assign zdet_cfg  = rf[8];

  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && ph == P_DEV && !dev_hit |=> !sda_oe); // R1
  AST_BADREG_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && ph == P_REG && !reg_ok |=> !sda_oe); // R4
  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ptr <= TOP_ADDR); // R4
  AST_REV_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr == 8'd1 |=> $stable(pwr_state) && $stable(port_cfg) && $stable(vol_l) && $stable(zdet_cfg)); // R5
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ptr == 8'd0 |=> pwr_state == 2'd0 && port_cfg == 16'h1812 && dac_ctl == 16'h0001 && vol_r == 16'h0190); // R6
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_q && scl_p && !start && !stop |=> $stable(sda_oe)); // R10
endmodule

// File: tb/sim_codec_ctl_regs.sv
`timescale 1ns/1ps
module sim_codec_ctl_regs;
  localparam int Q = 20;
  localparam logic [6:0] DEV = 7'h1A;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [1:0] pwr_state;
  logic [15:0] port_cfg, clk_cfg, dac_ctl, vol_l, vol_r, zdet_cfg;
  wire sda_bus = sda_m & ~sda_oe;
  int tests = 0, fails = 0, viol = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  codec_ctl_regs u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pwr_state(pwr_state), .port_cfg(port_cfg), .clk_cfg(clk_cfg), .dac_ctl(dac_ctl),
    .vol_l(vol_l), .vol_r(vol_r), .zdet_cfg(zdet_cfg));

  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe !== oe_prev) viol++;
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  function automatic logic [15:0] exp_def(input int i);
    case (i)
      0: return 16'h8523;
      1: return 16'h0001;
      3: return 16'h1812;
      5: return 16'h0001;
      6: return 16'h0190;
      7: return 16'h0190;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_w(input logic b);
    #Q sda_m = b; #Q scl_m = 1'b1; #(2*Q) scl_m = 1'b0;
  endtask
  task automatic bit_r(output logic b);
    #Q sda_m = 1'b1; #Q scl_m = 1'b1; #Q b = sda_bus; #Q scl_m = 1'b0;
  endtask
  task automatic i2c_start();
    #Q sda_m = 1'b1; #Q scl_m = 1'b1; #Q sda_m = 1'b0; #Q scl_m = 1'b0;
  endtask
  task automatic i2c_stop();
    #Q sda_m = 1'b0; #Q scl_m = 1'b1; #Q sda_m = 1'b1; #Q;
  endtask
  task automatic byte_w(input logic [7:0] d, output logic ok);
    logic nb;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(nb);
    ok = ~nb;
  endtask
  task automatic byte_r(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_r(b);
      d[i] = b;
    end
    bit_w(nack);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [15:0] v, output logic ok);
    logic k0, k1, k2, k3;
    k2 = 1'b0; k3 = 1'b0;
    i2c_start();
    byte_w({DEV, 1'b0}, k0);
    byte_w(a, k1);
    if (k1) begin byte_w(v[15:8], k2); byte_w(v[7:0], k3); end
    i2c_stop();
    ok = k0 & k1 & k2 & k3;
  endtask

  task automatic reg_rd(input logic [7:0] a, input int nbytes, output logic [31:0] v, output logic ok);
    logic k0, k1, k2;
    logic [7:0] b;
    v = 32'd0;
    i2c_start();
    byte_w({DEV, 1'b0}, k0);
    byte_w(a, k1);
    i2c_start();
    byte_w({DEV, 1'b1}, k2);
    for (int i = 0; i < nbytes; i++) begin
      byte_r(i == nbytes - 1, b);
      v = {v[23:0], b};
    end
    i2c_stop();
    ok = k0 & k1 & k2;
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'hA5C3 ^ (16'(i) * 16'h1111);
  endfunction

  logic [15:0] exp_r [0:8];

  task automatic check_outputs(input string req);
    check(req, {30'd0, pwr_state}, {30'd0, exp_r[2][1:0]});
    check(req, {16'd0, port_cfg}, {16'd0, exp_r[3]});
    check(req, {16'd0, clk_cfg},  {16'd0, exp_r[4]});
    check(req, {16'd0, dac_ctl},  {16'd0, exp_r[5]});
    check(req, {16'd0, vol_l},    {16'd0, exp_r[6]});
    check(req, {16'd0, vol_r},    {16'd0, exp_r[7]});
    check(req, {16'd0, zdet_cfg}, {16'd0, exp_r[8]});
  endtask

  initial begin
    logic ok;
    logic [31:0] v;
    for (int i = 0; i < 9; i++) exp_r[i] = exp_def(i);
    #40;
    check("R11 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    #40;
    check("R11 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    check_outputs("R7 R11 defaults");

    for (int i = 0; i < 9; i++) begin
      reg_rd(8'(i), 2, v, ok);
      check("R3 read ack", {31'd0, ok}, 32'd1);
      check(i < 2 ? "R5 id read" : "R7 default read", v, {16'd0, exp_def(i)});
    end

    foreach (exp_r[i]) if (i == 0) begin end
    begin
      logic [6:0] bad [4] = '{7'h00, 7'h1B, 7'h5A, 7'h1A ^ 7'h40};
      for (int k = 0; k < 4; k++) begin
        logic a;
        i2c_start();
        byte_w({bad[k], 1'b0}, a);
        i2c_stop();
        check("R1 foreign address nack", {31'd0, a}, 32'd0);
      end
      check_outputs("R1 nothing changed");
    end

    for (int i = 2; i < 9; i++) begin
      reg_wr(8'(i), pat(i), ok);
      exp_r[i] = pat(i);
      check("R2 write acks", {31'd0, ok}, 32'd1);
      reg_rd(8'(i), 2, v, ok);
      check("R2 R3 readback", v, {16'd0, pat(i)});
    end
    check_outputs("R2 R7 outputs follow writes");

    for (int p = 0; p < 4; p++) begin
      reg_wr(8'd2, 16'(p), ok);
      exp_r[2] = 16'(p);
      check("R8 power state", {30'd0, pwr_state}, 32'(p));
    end

    reg_wr(8'd1, 16'hFFFF, ok);
    check("R5 rev write acked", {31'd0, ok}, 32'd1);
    reg_rd(8'd1, 2, v, ok);
    check("R5 rev unchanged", v, 32'h0000_0001);
    check_outputs("R5 outputs unchanged");

    reg_rd(8'd6, 4, v, ok);
    check("R9 repeated word", v, {exp_r[6], exp_r[6]});

    begin
      logic [7:0] badr [3] = '{8'd9, 8'h0F, 8'hFF};
      for (int k = 0; k < 3; k++) begin
        logic k0, k1;
        i2c_start();
        byte_w({DEV, 1'b0}, k0);
        byte_w(badr[k], k1);
        i2c_stop();
        check("R4 bad index nack", {31'd0, k1}, 32'd0);
      end
      check_outputs("R4 nothing changed");
    end

    reg_wr(8'd0, 16'h1234, ok);
    for (int i = 2; i < 9; i++) exp_r[i] = exp_def(i);
    check_outputs("R6 soft reset");
    reg_rd(8'd0, 2, v, ok);
    check("R6 id after soft reset", v, 32'h0000_8523);
    reg_rd(8'd6, 2, v, ok);
    check("R6 volume default", v, 32'h0000_0190);

    check("R10 sda_oe stable while SCL high", 32'(viol), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule